// File: doc/BRIEF.md
# 128-bit Lane Permute Unit

This block rearranges lanes of a wide register datapath. Each operation takes two source vectors, A and B, plus their register indices, a 4-bit operation code and a destination index. It returns one registered result vector with a write enable for the register file. The vector is split into four words, numbered from w0 (least significant) to w3, so the width is four words. Halfwords and bytes are numbered upward from bit 0 in the same way.

The unit supports the following shuffles:
- Interleave of the low half of both sources, at byte, halfword or word granularity.
- Interleave of the high half at word granularity.
- Even-word pack.
- Copies of the low or high doubleword.
- Halfword broadcast within each half.
- Rotation of the lower three words.

A source whose index is 0 is read as all zeros. A destination index of 0 turns the operation into a no-op. The result appears one clock after the request, together with a valid flag and the destination index.

Top module: `lperm_unit`

## Requirements
- R1: While reset is active and in the first cycle after it, `res_valid` and `res_wen` are 0 and `res_data` is 0.
- R2: `res_valid` is high exactly in the cycle after a cycle with `req_valid` high. `res_wen` is never high without `res_valid`.
- R3: Codes 0, 1 and 2 interleave the low half at 8-, 16- and 32-bit lanes. Lane i of B's low half goes to result lane 2i, and lane i of A's low half goes to result lane 2i+1.
- R4: Code 3 interleaves the high half at word lanes. The result is w0=B.w2, w1=A.w2, w2=B.w3, w3=A.w3.
- R5: Code 4 packs even words: w0=B.w0, w1=B.w2, w2=A.w0, w3=A.w2.
- R6: Code 5 gives {A low 64 bits, B low 64 bits}, with B's bits in the result's low half. Code 6 gives {B high 64 bits, A high 64 bits}, with A's bits in the result's low half.
- R7: Code 7 copies B halfword 0 into halfwords 0 to 3 and B halfword 4 into halfwords 4 to 7.
- R8: Code 8 produces w0=B.w1, w1=B.w2, w2=B.w0, and passes w3=B.w3 through unchanged.
- R9: A source whose index is 0 is treated as all zeros, whatever its data port carries.
- R10: A destination index of 0 gives `res_wen`=0 and `res_data`=0.
- R11: Codes 9 to 15 give `res_wen`=0 and `res_data`=0.
- R12: When `res_valid` is high, `res_rd` equals the destination index of the request from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation code |
| req_rd | input | 5 | Destination register index |
| req_a_idx | input | 5 | Register index of source A |
| req_b_idx | input | 5 | Register index of source B |
| req_a | input | 128 | Source A data |
| req_b | input | 128 | Source B data |
| res_valid | output | 1 | Result present |
| res_wen | output | 1 | Result is to be written |
| res_rd | output | 5 | Destination index of the result |
| res_data | output | 128 | Result vector, zero when not written |

## Verification
Every cycle, the assertions check the following:
- The one-cycle valid timing.
- That the write enable never appears without valid.
- That the destination index is echoed.
- The suppression of writes for index 0 and for unused codes.
- That the rotate passes word 3 through.

Whether each shuffle puts every lane in exactly the right place can only be shown by the bench's directed and random vectors. The bench compares every result against a lane-by-lane model, including when source indices are zero.

// File: rtl/lperm_pkg.sv
package lperm_pkg;

   typedef enum logic [3:0] {
      OP_ILO_B   = 4'd0,
      OP_ILO_H   = 4'd1,
      OP_ILO_W   = 4'd2,
      OP_IHI_W   = 4'd3,
      OP_PACK_EW = 4'd4,
      OP_CPY_LD  = 4'd5,
      OP_CPY_UD  = 4'd6,
      OP_REP_H   = 4'd7,
      OP_ROT3_W  = 4'd8
   } perm_op_e;

   localparam int unsigned OP_W    = 4;
   localparam int unsigned N_ILO   = 3;

endpackage

// File: rtl/lperm_src_gate.sv
module lperm_src_gate #(
   parameter int unsigned DATA_W = 128,
   parameter int unsigned IDX_W  = 5
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] eff
);
   // Register index zero is the hardwired zero register.
   assign eff = (idx == '0) ? '0 : data;
endmodule

// File: rtl/lperm_interleave.sv
module lperm_interleave #(
   parameter int unsigned DATA_W = 128,
   parameter int unsigned LANE_W = 8,
   parameter bit          UPPER  = 1'b0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   localparam int unsigned HALF_W = DATA_W / 2;
   localparam int unsigned NLANES = HALF_W / LANE_W;
   localparam int unsigned BASE   = UPPER ? HALF_W : 0;

   if ((HALF_W % LANE_W) != 0) begin : g_bad_lane
      $error("lperm_interleave: LANE_W must divide half the data width");
   end

   for (genvar i = 0; i < NLANES; i++) begin : g_lane
      assign y[(2*i)*LANE_W   +: LANE_W] = b[BASE + i*LANE_W +: LANE_W];
      assign y[(2*i+1)*LANE_W +: LANE_W] = a[BASE + i*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/lperm_word_shuffle.sv
module lperm_word_shuffle #(
   parameter int unsigned WORD_W = 32
) (
   input  logic [4*WORD_W-1:0] a,
   input  logic [4*WORD_W-1:0] b,
   output logic [4*WORD_W-1:0] pack_ev,
   output logic [4*WORD_W-1:0] cpy_lo,
   output logic [4*WORD_W-1:0] cpy_hi,
   output logic [4*WORD_W-1:0] rep_h,
   output logic [4*WORD_W-1:0] rot3
);
   localparam int unsigned HW_W  = WORD_W / 2;
   localparam int unsigned DW_W  = 2 * WORD_W;
   localparam int unsigned HW_PH = DW_W / HW_W;

   logic [WORD_W-1:0] aw [4];
   logic [WORD_W-1:0] bw [4];

   for (genvar w = 0; w < 4; w++) begin : g_split
      assign aw[w] = a[w*WORD_W +: WORD_W];
      assign bw[w] = b[w*WORD_W +: WORD_W];
   end

   assign pack_ev = {aw[2], aw[0], bw[2], bw[0]};
   assign cpy_lo  = {a[DW_W-1:0], b[DW_W-1:0]};
   assign cpy_hi  = {b[2*DW_W-1:DW_W], a[2*DW_W-1:DW_W]};
   assign rot3    = {bw[3], bw[0], bw[2], bw[1]};

   for (genvar h = 0; h < HW_PH; h++) begin : g_rep
      assign rep_h[h*HW_W +: HW_W]        = b[HW_W-1:0];
      assign rep_h[DW_W + h*HW_W +: HW_W] = b[DW_W +: HW_W];
   end
endmodule

// File: rtl/lperm_unit.sv
module lperm_unit #(
   parameter int unsigned DATA_W = 128,
   parameter int unsigned IDX_W  = 5
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic [lperm_pkg::OP_W-1:0]   req_op,
   input  logic [IDX_W-1:0]             req_rd,
   input  logic [IDX_W-1:0]             req_a_idx,
   input  logic [IDX_W-1:0]             req_b_idx,
   input  logic [DATA_W-1:0]            req_a,
   input  logic [DATA_W-1:0]            req_b,
   output logic                         res_valid,
   output logic                         res_wen,
   output logic [IDX_W-1:0]             res_rd,
   output logic [DATA_W-1:0]            res_data
);
   import lperm_pkg::*;

   localparam int unsigned WORD_W = DATA_W / 4;

   if ((DATA_W % 64) != 0 || (WORD_W % 16) != 0) begin : g_bad_width
      $error("lperm_unit: DATA_W must be a multiple of 64 with 16-bit aligned words");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("lperm_unit: IDX_W must be at least 1");
   end

   logic [DATA_W-1:0] a_eff, b_eff;

   lperm_src_gate #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_gate_a (
      .idx(req_a_idx), .data(req_a), .eff(a_eff));
   lperm_src_gate #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_gate_b (
      .idx(req_b_idx), .data(req_b), .eff(b_eff));

   // Low-half interleavers at byte, halfword and word lanes.
   logic [DATA_W-1:0] ilo [N_ILO];
   for (genvar g = 0; g < N_ILO; g++) begin : g_ilo
      localparam int unsigned LW = (g == 0) ? 8 : (g == 1) ? WORD_W/2 : WORD_W;
      lperm_interleave #(.DATA_W(DATA_W), .LANE_W(LW), .UPPER(1'b0)) u_ilv (
         .a(a_eff), .b(b_eff), .y(ilo[g]));
   end

   logic [DATA_W-1:0] ihi_w;
   lperm_interleave #(.DATA_W(DATA_W), .LANE_W(WORD_W), .UPPER(1'b1)) u_ihi (
      .a(a_eff), .b(b_eff), .y(ihi_w));

   logic [DATA_W-1:0] pack_ev, cpy_lo, cpy_hi, rep_h, rot3;
   lperm_word_shuffle #(.WORD_W(WORD_W)) u_shuf (
      .a(a_eff), .b(b_eff), .pack_ev(pack_ev), .cpy_lo(cpy_lo),
      .cpy_hi(cpy_hi), .rep_h(rep_h), .rot3(rot3));

   logic [DATA_W-1:0] sel;
   logic              known;

   always_comb begin
      known = 1'b1;
      sel   = '0;
      case (req_op)
         OP_ILO_B:   sel = ilo[0];
         OP_ILO_H:   sel = ilo[1];
         OP_ILO_W:   sel = ilo[2];
         OP_IHI_W:   sel = ihi_w;
         OP_PACK_EW: sel = pack_ev;
         OP_CPY_LD:  sel = cpy_lo;
         OP_CPY_UD:  sel = cpy_hi;
         OP_REP_H:   sel = rep_h;
         OP_ROT3_W:  sel = rot3;
         default:    known = 1'b0;
      endcase
   end

   logic do_wr;
   assign do_wr = req_valid && known && (req_rd != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_wen   <= 1'b0;
         res_rd    <= '0;
         res_data  <= '0;
      end else begin
         res_valid <= req_valid;
         res_wen   <= do_wr;
         if (req_valid) res_rd <= req_rd;
         res_data  <= do_wr ? sel : '0;
      end
   end
endmodule

// File: rtl/lperm_unit_chk.sv
module lperm_unit_chk #(
   parameter int unsigned DATA_W = 128,
   parameter int unsigned IDX_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [3:0]        req_op,
   input logic [IDX_W-1:0]  req_rd,
   input logic [IDX_W-1:0]  req_b_idx,
   input logic [DATA_W-1:0] req_b,
   input logic              res_valid,
   input logic              res_wen,
   input logic [IDX_W-1:0]  res_rd,
   input logic [DATA_W-1:0] res_data
);
   localparam int unsigned WORD_W = DATA_W / 4;

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);
   // R2
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid);
   // R2
   wen_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_wen |-> res_valid);
   // R10
   rd_zero_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_rd == '0) |=> (!res_wen && res_data == '0));
   // R11
   bad_op_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op > 4'd8) |=> (!res_wen && res_data == '0));
   // R12
   rd_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (res_rd == $past(req_rd)));
   // R8
   rot_keep_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 4'd8 && req_rd != '0) |=>
      (res_data[DATA_W-1 -: WORD_W] ==
       (($past(req_b_idx) == '0) ? '0 : $past(req_b[DATA_W-1 -: WORD_W]))));
endmodule

bind lperm_unit lperm_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
   .req_rd(req_rd), .req_b_idx(req_b_idx), .req_b(req_b),
   .res_valid(res_valid), .res_wen(res_wen), .res_rd(res_rd),
   .res_data(res_data));

// File: tb/lperm_unit_tb.sv
`timescale 1ns/1ps
module lperm_unit_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [3:0]   req_op = '0;
   logic [4:0]   req_rd = '0, req_a_idx = '0, req_b_idx = '0;
   logic [127:0] req_a = '0, req_b = '0;
   logic         res_valid, res_wen;
   logic [4:0]   res_rd;
   logic [127:0] res_data;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   lperm_unit u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_rd(req_rd), .req_a_idx(req_a_idx), .req_b_idx(req_b_idx),
      .req_a(req_a), .req_b(req_b), .res_valid(res_valid), .res_wen(res_wen),
      .res_rd(res_rd), .res_data(res_data));

   function automatic logic [31:0] wd(logic [127:0] v, int k);
      return v[32*k +: 32];
   endfunction

   function automatic logic [127:0] ilv(logic [127:0] a, logic [127:0] b, int lw, int base);
      logic [127:0] r = '0;
      for (int j = 0; j < 64; j++) begin
         int k = j / lw;
         int o = j % lw;
         r[2*k*lw + o]      = b[base + j];
         r[(2*k+1)*lw + o]  = a[base + j];
      end
      return r;
   endfunction

   function automatic bit known_op(logic [3:0] op);
      return op <= 4'd8;
   endfunction

   function automatic logic [127:0] model(logic [3:0] op, logic [4:0] ai, logic [4:0] bi,
                                          logic [127:0] ain, logic [127:0] bin);
      logic [127:0] a = (ai == 0) ? '0 : ain;
      logic [127:0] b = (bi == 0) ? '0 : bin;
      case (op)
         4'd0: return ilv(a, b, 8, 0);
         4'd1: return ilv(a, b, 16, 0);
         4'd2: return ilv(a, b, 32, 0);
         4'd3: return {wd(a,3), wd(b,3), wd(a,2), wd(b,2)};
         4'd4: return {wd(a,2), wd(a,0), wd(b,2), wd(b,0)};
         4'd5: return {a[63:0], b[63:0]};
         4'd6: return {b[127:64], a[127:64]};
         4'd7: return {{4{b[79:64]}}, {4{b[15:0]}}};
         4'd8: return {wd(b,3), wd(b,0), wd(b,2), wd(b,1)};
         default: return '0;
      endcase
   endfunction

   function automatic string tag_of(logic [3:0] op, logic [4:0] rd);
      if (rd == 0) return "R10";
      case (op)
         4'd0, 4'd1, 4'd2: return "R3";
         4'd3: return "R4";
         4'd4: return "R5";
         4'd5, 4'd6: return "R6";
         4'd7: return "R7";
         4'd8: return "R8";
         default: return "R11";
      endcase
   endfunction

   task automatic compare(string tag, bit ev, bit ew, logic [4:0] erd, logic [127:0] ed);
      n_vec++;
      if (res_valid !== ev || res_wen !== ew || (ev && res_rd !== erd) || res_data !== ed) begin
         n_bad++;
         $display("FAIL %s: got v=%0b w=%0b rd=%0d d=%h, expected v=%0b w=%0b rd=%0d d=%h",
                  tag, res_valid, res_wen, res_rd, res_data, ev, ew, erd, ed);
      end
   endtask

   // Drive one request at a falling edge, check it at the next falling edge.
   task automatic run(string tag, logic [3:0] op, logic [4:0] rd, logic [4:0] ai,
                      logic [4:0] bi, logic [127:0] a, logic [127:0] b);
      bit w = known_op(op) && rd != 0;
      req_valid = 1'b1; req_op = op; req_rd = rd;
      req_a_idx = ai; req_b_idx = bi; req_a = a; req_b = b;
      @(negedge clk);
      compare(tag, 1'b1, w, rd, w ? model(op, ai, bi, a, b) : '0);
   endtask

   localparam logic [127:0] PA = 128'hA3A2A1A0_A7A6A5A4_ABAAA9A8_AFAEADAC;
   localparam logic [127:0] PB = 128'hB3B2B1B0_B7B6B5B4_BBBAB9B8_BFBEBDBC;

   initial begin
      void'($urandom(32'h1F2E3D4C));
      repeat (3) @(negedge clk);
      compare("R1", 1'b0, 1'b0, 5'd0, '0);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1", 1'b0, 1'b0, 5'd0, '0);

      // Directed: fixed lane placements.
      run("R3", 4'd0, 5'd3, 5'd1, 5'd2, PA, PB);
      run("R3", 4'd1, 5'd3, 5'd1, 5'd2, PA, PB);
      run("R3", 4'd2, 5'd3, 5'd1, 5'd2, PA, PB);
      run("R4", 4'd3, 5'd4, 5'd1, 5'd2, PA, PB);
      run("R5", 4'd4, 5'd5, 5'd1, 5'd2, PA, PB);
      run("R6", 4'd5, 5'd6, 5'd1, 5'd2, PA, PB);
      run("R6", 4'd6, 5'd6, 5'd1, 5'd2, PA, PB);
      run("R7", 4'd7, 5'd7, 5'd1, 5'd2, PA, PB);
      run("R8", 4'd8, 5'd8, 5'd1, 5'd2, PA, PB);
      // R9: zero source indices hide nonzero data.
      run("R9", 4'd2, 5'd9, 5'd0, 5'd2, PA, PB);
      run("R9", 4'd8, 5'd9, 5'd1, 5'd0, PA, PB);
      run("R9", 4'd5, 5'd9, 5'd0, 5'd0, PA, PB);
      // R10 and R11 corner cases.
      run("R10", 4'd4, 5'd0, 5'd1, 5'd2, PA, PB);
      run("R11", 4'd9, 5'd1, 5'd1, 5'd2, PA, PB);
      run("R11", 4'd15, 5'd31, 5'd1, 5'd2, PA, PB);
      // R2: idle cycle gives no result.
      req_valid = 1'b0;
      @(negedge clk);
      compare("R2", 1'b0, 1'b0, 5'd0, '0);
      // R12: echoed index on back-to-back requests.
      run("R12", 4'd7, 5'd17, 5'd3, 5'd4, PA, PB);
      run("R12", 4'd0, 5'd30, 5'd3, 5'd4, PB, PA);

      // Random mix.
      for (int n = 0; n < 3000; n++) begin
         logic [3:0]   op = 4'($urandom_range(0, 15));
         logic [4:0]   rd = ($urandom_range(0, 7) == 0) ? 5'd0 : 5'($urandom_range(1, 31));
         logic [4:0]   ai = ($urandom_range(0, 7) == 0) ? 5'd0 : 5'($urandom_range(1, 31));
         logic [4:0]   bi = ($urandom_range(0, 7) == 0) ? 5'd0 : 5'($urandom_range(1, 31));
         logic [127:0] a  = {$urandom, $urandom, $urandom, $urandom};
         logic [127:0] b  = {$urandom, $urandom, $urandom, $urandom};
         if ($urandom_range(0, 9) == 0) begin
            req_valid = 1'b0;
            @(negedge clk);
            compare("R2", 1'b0, 1'b0, 5'd0, '0);
         end
         run(tag_of(op, rd), op, rd, ai, bi, a, b);
      end
      req_valid = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule